// File: doc/BRIEF.md
# Three-Channel Slotted LED Duty Modulator

This block turns three 5-bit brightness codes into three on/off enables for LED current sinks. All three enables share one time base. A prescaler divides the 1 MHz system clock by 15 to make one slot. Thirty-one slots make one modulation period of 465 clocks, which gives about 2.15 kHz. A lane's enable is high while the slot index (0 to 30) is below that lane's active code. Code 0 therefore keeps the LED dark, and code 31 keeps it lit for the whole period. Each code step is 1/31 of full scale.

Software may write a lane's code at any moment. Each write goes into a pending register and is copied into the active register only at the next period start, so a write never cuts a pulse short or adds a stray one. A shutdown input blanks all three enables in the same cycle it is asserted. It also clears every code to zero and parks the time base. When shutdown is released, a new period begins on the very next clock edge.

A two-state controller drives the sequencing:
- **ST_IDLE**: reset or shutdown; the counters are held at zero and the enables are low.
- **ST_RUN**: the counters advance.

It has three transitions:
- **IDLE→RUN** when shutdown is low. This is the start of the first period, and the pending codes are applied.
- **RUN→IDLE** when shutdown is high.
- **RUN→RUN** otherwise. The pending codes are applied on the last cycle of each period.

Top module: `tri_pwm_dimmer`

## Requirements
- R1: During and after reset, all enables are low and every lane's pending and active code is 0, so the first period after reset is fully dark.
- R2: A period is 31 slots of PRESCALE (15) clocks, 465 clocks in all. Within a period, lane c is high in clock k (0 to 464, counted from the period's first clock) exactly when floor(k/15) < code_c. The pulse is therefore one block at the start of the period.
- R3: Code 0 keeps a lane low for the whole period.
- R4: Code 31 keeps a lane high in every clock of the period, including across the wrap into the next period.
- R5: The three lanes are independent: each lane's waveform depends only on its own code.
- R6: A strobed write lands in the lane's pending register. The period in progress keeps the old code, and the new code applies from the next period start.
- R7: A write strobed in the last clock of a period applies to the period that starts on the next clock.
- R8: While shutdown is high, all enables are low in the same cycle (no register delay).
- R9: Shutdown clears pending and active codes to 0 and restarts the time base. Writes strobed while shutdown is high are ignored.
- R10: After shutdown falls, the next clock edge starts a period at slot 0. A write strobed in that same cycle applies to this first period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock (1 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shutdown_i | input | 1 | Blanks all enables, clears codes, parks time base |
| duty_i | input | N_CH*CODE_W | Packed codes; lane c at bits [c*CODE_W +: CODE_W] (lane 0 red, 1 green, 2 blue) |
| load_i | input | N_CH | Per-lane write strobe for duty_i |
| en_o | output | N_CH | Per-lane LED enable, bit c for lane c |

## Verification
Some behaviours are checked by assertions on every clock:
- blanking of all enables under shutdown;
- a zero code never lighting a lane, and a full code never leaving it dark;
- the counters staying in range;
- an active code holding still between period starts;
- codes being cleared by shutdown;
- an enable rising only at slot 0.

Other behaviours can only be shown by the bench's scenarios:
- the exact number of lit clocks for each code and their position within the period;
- the lanes not affecting each other;
- a write landing one period late, or on the boundary itself;
- writes made under shutdown being dropped.

The bench shows these by sweeping all 32 codes and comparing every clock of each period with floor(k/15) < code.

// File: rtl/tri_pwm_pkg.sv
package tri_pwm_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // Index of the final slot in a period: 2**w - 2 (31 slots for w = 5)
    function automatic int unsigned last_slot(input int unsigned w);
        return (1 << w) - 2;
    endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int unsigned CODE_W   = 5,
    parameter int unsigned PRESCALE = 15,
    localparam int unsigned PRE_W   = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    output logic [CODE_W-1:0] slot_o,
    output logic [PRE_W-1:0]  pre_o,
    output logic              period_end_o
);

    localparam logic [CODE_W-1:0] LAST   = CODE_W'(tri_pwm_pkg::last_slot(CODE_W));
    localparam logic [PRE_W-1:0]  PRE_TOP = PRE_W'(PRESCALE - 1);

    logic [CODE_W-1:0] slot_q;
    logic [PRE_W-1:0]  pre_q;
    logic              pre_wrap;
    logic              slot_wrap;

    assign pre_wrap  = (pre_q == PRE_TOP);
    assign slot_wrap = (slot_q == LAST);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pre_q  <= '0;
            slot_q <= '0;
        end else if (!run_i) begin
            pre_q  <= '0;
            slot_q <= '0;
        end else if (pre_wrap) begin
            pre_q  <= '0;
            slot_q <= slot_wrap ? '0 : slot_q + 1'b1;
        end else begin
            pre_q  <= pre_q + 1'b1;
        end
    end

    assign slot_o       = slot_q;
    assign pre_o        = pre_q;
    assign period_end_o = run_i && pre_wrap && slot_wrap;

endmodule

// File: rtl/pwm_lane.sv
module pwm_lane #(
    parameter int unsigned CODE_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clear_i,
    input  logic              load_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              apply_i,
    input  logic [CODE_W-1:0] slot_i,
    output logic [CODE_W-1:0] active_o,
    output logic              lit_o
);

    logic [CODE_W-1:0] pending_q;
    logic [CODE_W-1:0] active_q;
    logic [CODE_W-1:0] next_pending;

    // A strobe in the applying cycle bypasses the pending stage
    assign next_pending = load_i ? code_i : pending_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pending_q <= '0;
            active_q  <= '0;
        end else if (clear_i) begin
            pending_q <= '0;
            active_q  <= '0;
        end else begin
            pending_q <= next_pending;
            if (apply_i) begin
                active_q <= next_pending;
            end
        end
    end

    assign active_o = active_q;
    assign lit_o    = (slot_i < active_q);

endmodule

// File: rtl/tri_pwm_dimmer.sv
module tri_pwm_dimmer #(
    parameter int unsigned N_CH     = 3,
    parameter int unsigned CODE_W   = 5,
    parameter int unsigned PRESCALE = 15
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     shutdown_i,
    input  logic [N_CH*CODE_W-1:0]   duty_i,
    input  logic [N_CH-1:0]          load_i,
    output logic [N_CH-1:0]          en_o
);

    import tri_pwm_pkg::*;

    localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    run_state_e              state_q;
    run_state_e              state_d;
    logic                    run_ok;
    logic                    apply;
    logic                    period_end;
    logic [CODE_W-1:0]       slot_q;
    logic [PRE_W-1:0]        pre_q;
    logic [N_CH-1:0]         lit;
    logic [N_CH*CODE_W-1:0]  active_flat;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and control outputs
    always_comb begin
        state_d = state_q;
        apply   = 1'b0;
        run_ok  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!shutdown_i) begin
                    state_d = ST_RUN;
                    apply   = 1'b1;
                end
            end
            ST_RUN: begin
                if (shutdown_i) begin
                    state_d = ST_IDLE;
                end else begin
                    run_ok = 1'b1;
                    apply  = period_end;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    pwm_timebase #(
        .CODE_W   (CODE_W),
        .PRESCALE (PRESCALE)
    ) u_timebase (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .run_i        (run_ok),
        .slot_o       (slot_q),
        .pre_o        (pre_q),
        .period_end_o (period_end)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_lane
        pwm_lane #(
            .CODE_W (CODE_W)
        ) u_lane (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .clear_i  (shutdown_i),
            .load_i   (load_i[c]),
            .code_i   (duty_i[c*CODE_W +: CODE_W]),
            .apply_i  (apply),
            .slot_i   (slot_q),
            .active_o (active_flat[c*CODE_W +: CODE_W]),
            .lit_o    (lit[c])
        );
    end

    // Output process: blanking by shutdown has no register in its path
    always_comb begin
        en_o = '0;
        if (state_q == ST_RUN && !shutdown_i) begin
            en_o = lit;
        end
    end

endmodule

// File: rtl/tri_pwm_checker.sv
module tri_pwm_checker #(
    parameter int unsigned N_CH     = 3,
    parameter int unsigned CODE_W   = 5,
    parameter int unsigned PRESCALE = 15,
    localparam int unsigned PRE_W   = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic                    shutdown_i,
    input logic [N_CH-1:0]         en_o,
    input logic                    running,
    input logic                    period_end,
    input logic [CODE_W-1:0]       slot_q,
    input logic [PRE_W-1:0]        pre_q,
    input logic [N_CH*CODE_W-1:0]  active_flat
);

    localparam int unsigned LAST = tri_pwm_pkg::last_slot(CODE_W);

    // R8: shutdown blanks everything in the same cycle
    a_r8_shutdown_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shutdown_i |-> (en_o == '0));

    // R2: time base stays within its slot and prescale ranges
    a_r2_counter_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(slot_q) <= LAST) && (int'(pre_q) < PRESCALE));

    // R6: active codes only move at a period start or under shutdown
    a_r6_hold_midperiod: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running && !period_end && !shutdown_i) |=> $stable(active_flat));

    // R9: shutdown leaves every active code at zero
    a_r9_shutdown_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shutdown_i |=> (active_flat == '0));

    for (genvar c = 0; c < N_CH; c++) begin : g_lane_chk
        // R3: a zero code never lights its lane
        a_r3_zero_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (active_flat[c*CODE_W +: CODE_W] == '0) |-> !en_o[c]);

        // R4: a full code keeps its lane lit while running
        a_r4_full_lit: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (running && !shutdown_i && (active_flat[c*CODE_W +: CODE_W] == '1)) |-> en_o[c]);

        // R2: a pulse begins only at the first clock of a period
        a_r2_rise_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(en_o[c]) |-> (slot_q == '0 && pre_q == '0));
    end

endmodule

bind tri_pwm_dimmer tri_pwm_checker #(
    .N_CH     (N_CH),
    .CODE_W   (CODE_W),
    .PRESCALE (PRESCALE)
) u_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .shutdown_i  (shutdown_i),
    .en_o        (en_o),
    .running     (state_q == tri_pwm_pkg::ST_RUN),
    .period_end  (period_end),
    .slot_q      (slot_q),
    .pre_q       (pre_q),
    .active_flat (active_flat)
);

// File: tb/test_tri_pwm_dimmer.sv
`timescale 1ns/1ps
module test_tri_pwm_dimmer;

    localparam int N_CH   = 3;
    localparam int CW     = 5;
    localparam int PRE    = 15;
    localparam int PERIOD = 31 * PRE;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            shutdown = 1'b0;
    logic [N_CH*CW-1:0] duty = '0;
    logic [N_CH-1:0] load = '0;
    logic [N_CH-1:0] en;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    tri_pwm_dimmer #(.N_CH(N_CH), .CODE_W(CW), .PRESCALE(PRE)) i_tri_pwm_dimmer (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .shutdown_i (shutdown),
        .duty_i     (duty),
        .load_i     (load),
        .en_o       (en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Caller has just passed the edge that starts a period. Compares every clock
    // against floor(k/PRE) < code; optionally strobes one write after sample wk.
    task automatic check_period(input int c0, input int c1, input int c2, input string req,
                                input bit wr, input int wk, input int wch, input int wcode);
        int codes[3];
        int miss[3];
        int hi[3];
        codes[0] = c0; codes[1] = c1; codes[2] = c2;
        for (int c = 0; c < 3; c++) begin miss[c] = 0; hi[c] = 0; end
        for (int k = 0; k < PERIOD; k++) begin
            @(negedge clk);
            load = '0;
            for (int c = 0; c < 3; c++) begin
                if (en[c] != ((k / PRE) < codes[c])) miss[c]++;
                if (en[c]) hi[c]++;
            end
            if (wr && k == wk) begin
                duty[wch*CW +: CW] = CW'(wcode);
                load[wch] = 1'b1;
            end
        end
        for (int c = 0; c < 3; c++)
            check(miss[c] == 0, $sformatf("%s lane%0d code%0d lit clocks", req, c, codes[c]),
                  hi[c], codes[c] * PRE);
    endtask

    // Shutdown pulse, then release with all three codes strobed (R10 path)
    task automatic start(input int c0, input int c1, input int c2);
        @(negedge clk);
        shutdown = 1'b1;
        load = '0;
        @(negedge clk);
        shutdown = 1'b0;
        duty = {CW'(c2), CW'(c1), CW'(c0)};
        load = '1;
        @(posedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(en == '0, "R1 enables in reset", en, 0);
        rst_n = 1'b1;
        @(posedge clk);
        check_period(0, 0, 0, "R1 codes zero after reset", 1'b0, 0, 0, 0);

        // R2 R3 R4 R5 R10: sweep every code, distinct codes per lane
        for (int c = 0; c < 32; c++) begin
            int g = 31 - c;
            int b = (c * 11) % 32;
            start(c, g, b);
            check_period(c, g, b, (c == 0) ? "R3" : (c == 31) ? "R4" : "R2 R5 R10",
                         1'b0, 0, 0, 0);
        end

        // R6: mid-period write waits; R7: write in last clock applies next
        start(4, 10, 20);
        check_period(4, 10, 20, "R6 old code holds", 1'b1, 100, 0, 25);
        check_period(25, 10, 20, "R6 new code next period", 1'b1, PERIOD - 1, 2, 3);
        check_period(25, 10, 3, "R7 boundary write", 1'b0, 0, 0, 0);

        // R4 across wrap then R8: immediate blanking
        start(31, 31, 31);
        check_period(31, 31, 31, "R4 full", 1'b0, 0, 0, 0);
        repeat (7) @(negedge clk);
        check(en == 3'b111, "R4 lit before shutdown", en, 7);
        shutdown = 1'b1;
        #1;
        check(en == '0, "R8 same-cycle blank", en, 0);

        // R9: writes under shutdown dropped, codes cleared
        @(negedge clk);
        duty = {5'd9, 5'd17, 5'd31};
        load = '1;
        @(negedge clk);
        load = '0;
        check(en == '0, "R8 held blank", en, 0);
        shutdown = 1'b0;
        @(posedge clk);
        check_period(0, 0, 0, "R9 cleared and writes ignored", 1'b0, 0, 0, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule